// File: doc/BRIEF.md
# Status Flag Set and Stop Unit

This unit owns a processor's eight-bit status register. It executes the instructions that force single flags on: carry, decimal mode and interrupt disable. It also executes an instruction that ORs an immediate byte into the whole register. A fifth instruction, stop, puts the unit into a halted state. That state persists and withholds the step enable from every later instruction.

The sequencer presents a decoded opcode with `op_valid` while `step_en` is high, and with it the immediate byte. The unit takes the opcode in that cycle and holds `busy` for the rest of the instruction's cycle count. It then pulses `done` for one cycle and reports the cycle count, a request to advance the program counter by one, and whether the opcode lay outside its set. Elsewhere in the processor, the register can be loaded through a write port while no instruction is in flight. Maskable interrupt requests pass through a gate that respects the interrupt-disable flag.

Top module: `status_setter`

## Requirements
- R1: After reset, `status` equals 8'h04 (interrupt disable set), `stopped`, `busy` and `done` are 0, and `step_en` is 1.
- R2: Opcode 8'h38, once accepted, sets status bit 0 (carry) and leaves every other bit unchanged. It takes 2 cycles: `done` is high in the second cycle after the accept cycle, with `ins_cycles` = 2.
- R3: Opcode 8'hF8 sets bit 3 (decimal) and opcode 8'h78 sets bit 2 (interrupt disable). Each leaves the other bits unchanged, takes 2 cycles and reports `ins_cycles` = 2.
- R4: Opcode 8'hE2 ORs the immediate byte sampled at accept into `status` and never clears a bit. It takes 3 cycles (`ins_cycles` = 3), and `pc_adv` is high together with its `done`.
- R5: Opcode 8'hDB raises `stopped` after 3 cycles (`ins_cycles` = 3), leaves `status` unchanged, and `stopped` then stays high until reset.
- R6: While `stopped` is high, `step_en` is low and `op_valid` has no effect: no `done`, no status change.
- R7: `irq_take` equals `irq_req` when status bit 2 is 0 and the unit is not stopped; otherwise it is 0.
- R8: `done` is high for one cycle per accepted instruction. `pc_adv`, `ins_cycles` and `unhandled` are 0 while `done` is low, and `pc_adv` is 0 for every opcode except 8'hE2.
- R9: Any other opcode completes in 1 cycle: `done` and `unhandled` are high in the next cycle, `ins_cycles` = 1, and `status` is unchanged.
- R10: `status_wr` loads `status_wdata` into `status` at the next edge when `busy` is low. It is ignored while `busy` is high.
- R11: While `busy` is high, `step_en` is low and `op_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode presented this cycle |
| opcode | input | 8 | Decoded instruction opcode |
| imm | input | 8 | Immediate byte for the mask instruction |
| status_wr | input | 1 | Load request for the status register |
| status_wdata | input | 8 | Value loaded by `status_wr` |
| irq_req | input | 1 | Maskable interrupt request |
| status | output | 8 | Status register |
| step_en | output | 1 | Unit can accept an opcode |
| stopped | output | 1 | Halted state |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Instruction completed (one cycle) |
| ins_cycles | output | 2 | Cycle count of the completed instruction |
| pc_adv | output | 1 | Advance program counter by one byte |
| unhandled | output | 1 | Completed opcode was outside the set |
| irq_take | output | 1 | Gated interrupt request |

## Verification
A wrong remaining-cycle count appears at once as `done` arriving a cycle early or late relative to the accept. A corrupted pending mask shows as a wrong `status` in the `done` cycle itself. A lost stop bit shows within one cycle as `step_en` rising again or an ignored opcode completing. A wrongly gated interrupt-disable bit shows combinationally on `irq_take` in the same cycle it is set.

// File: rtl/status_setter.sv
module status_setter #(
  parameter int W = 8,
  parameter int C_BIT = 0,
  parameter int I_BIT = 2,
  parameter int D_BIT = 3,
  parameter logic [W-1:0] RST_STATUS = 8'h04
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [7:0]   opcode,
  input  logic [W-1:0] imm,
  input  logic         status_wr,
  input  logic [W-1:0] status_wdata,
  input  logic         irq_req,
  output logic [W-1:0] status,
  output logic         step_en,
  output logic         stopped,
  output logic         busy,
  output logic         done,
  output logic [1:0]   ins_cycles,
  output logic         pc_adv,
  output logic         unhandled,
  output logic         irq_take
);
  localparam logic [7:0] OP_CARRY = 8'h38;
  localparam logic [7:0] OP_DEC   = 8'hF8;
  localparam logic [7:0] OP_IDIS  = 8'h78;
  localparam logic [7:0] OP_MASK  = 8'hE2;
  localparam logic [7:0] OP_HALT  = 8'hDB;

  logic [W-1:0] dec_mask, pend_mask;
  logic [1:0]   dec_len, pend_len, remain;
  logic         dec_known, dec_halt, dec_pc, pend_halt, pend_pc;
  logic         accept;

  assign step_en  = !busy && !stopped;
  assign accept   = op_valid && step_en;
  assign irq_take = irq_req && !status[I_BIT] && !stopped;

  always_comb begin
    dec_mask  = '0;
    dec_len   = 2'd1;
    dec_known = 1'b1;
    dec_halt  = 1'b0;
    dec_pc    = 1'b0;
    case (opcode)
      OP_CARRY: begin dec_mask[C_BIT] = 1'b1; dec_len = 2'd2; end
      OP_DEC:   begin dec_mask[D_BIT] = 1'b1; dec_len = 2'd2; end
      OP_IDIS:  begin dec_mask[I_BIT] = 1'b1; dec_len = 2'd2; end
      OP_MASK:  begin dec_mask = imm; dec_len = 2'd3; dec_pc = 1'b1; end
      OP_HALT:  begin dec_len = 2'd3; dec_halt = 1'b1; end
      default:  dec_known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status     <= RST_STATUS;
      stopped    <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      ins_cycles <= '0;
      pc_adv     <= 1'b0;
      unhandled  <= 1'b0;
      remain     <= '0;
      pend_mask  <= '0;
      pend_len   <= '0;
      pend_halt  <= 1'b0;
      pend_pc    <= 1'b0;
    end else begin
      done       <= 1'b0;
      ins_cycles <= '0;
      pc_adv     <= 1'b0;
      unhandled  <= 1'b0;
      if (busy) begin
        if (remain == 2'd1) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          status     <= status | pend_mask;
          stopped    <= stopped | pend_halt;
          ins_cycles <= pend_len;
          pc_adv     <= pend_pc;
        end else begin
          remain <= remain - 2'd1;
        end
      end else begin
        if (status_wr) status <= status_wdata;
        if (accept) begin
          if (!dec_known) begin
            done       <= 1'b1;
            unhandled  <= 1'b1;
            ins_cycles <= 2'd1;
          end else begin
            busy      <= 1'b1;
            remain    <= dec_len - 2'd1;
            pend_mask <= dec_mask;
            pend_len  <= dec_len;
            pend_halt <= dec_halt;
            pend_pc   <= dec_pc;
          end
        end
      end
    end
  end
endmodule

// File: rtl/status_setter_chk.sv
module status_setter_chk #(
  parameter int W = 8,
  parameter int I_BIT = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [W-1:0] status,
  input logic         step_en,
  input logic         stopped,
  input logic         busy,
  input logic         done,
  input logic         pc_adv,
  input logic         unhandled,
  input logic         irq_req,
  input logic         irq_take
);
  // R5
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> stopped);
  // R6
  stop_blocks_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !step_en);
  // R6
  stop_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stopped) && !$past(busy)) |-> !done);
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_req && !status[I_BIT] && !stopped));
  // R4
  status_never_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !unhandled) |-> ((status & $past(status)) == $past(status)));
  // R8
  pc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |-> (done && !unhandled));
  // R10
  busy_status_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(status));
  // R11
  busy_blocks_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !step_en);
endmodule

bind status_setter status_setter_chk #(.W(W), .I_BIT(I_BIT)) chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .status(status),
  .step_en(step_en), .stopped(stopped), .busy(busy), .done(done),
  .pc_adv(pc_adv), .unhandled(unhandled), .irq_req(irq_req),
  .irq_take(irq_take)
);

// File: tb/status_setter_test.sv
module status_setter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, status_wr = 1'b0, irq_req = 1'b0;
  logic [7:0] opcode = '0, imm = '0, status_wdata = '0;
  logic [7:0] status;
  logic step_en, stopped, busy, done, pc_adv, unhandled, irq_take;
  logic [1:0] ins_cycles;
  int checks = 0, fails = 0;
  logic [7:0] exp_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_setter uut (.*);

  function automatic int op_len(input logic [7:0] op);
    case (op)
      8'h38, 8'hF8, 8'h78: return 2;
      8'hE2, 8'hDB: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] op_mask(input logic [7:0] op, input logic [7:0] im);
    case (op)
      8'h38: return 8'h01;
      8'hF8: return 8'h08;
      8'h78: return 8'h04;
      8'hE2: return im;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_status = 8'h04;
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] im, input string req);
    int n = op_len(op);
    bit known = (n != 1);
    opcode = op; imm = im; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; imm = $urandom;
    for (int i = 1; i < n; i++) begin
      check({req, " done early"}, done, 0);
      check({req, " step_en while busy (R11)"}, step_en, 0);
      @(negedge clk);
    end
    exp_status = exp_status | op_mask(op, im);
    check({req, " done"}, done, 1);
    check({req, " ins_cycles"}, ins_cycles, n);
    check({req, " status"}, status, exp_status);
    check({req, " pc_adv (R8)"}, pc_adv, op == 8'hE2);
    check({req, " unhandled (R9)"}, unhandled, !known);
  endtask

  task automatic write_status(input logic [7:0] v);
    status_wr = 1'b1; status_wdata = v;
    @(negedge clk);
    status_wr = 1'b0;
    exp_status = v;
    check("R10 status load", status, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    process::self().srandom(32'd7781);
    do_reset();
    @(negedge clk);
    check("R1 status", status, 8'h04);
    check("R1 stopped", stopped, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 step_en", step_en, 1);

    write_status(8'h00);
    irq_req = 1'b1; #1;
    check("R7 irq passes", irq_take, 1);
    issue(8'h38, 8'h00, "R2 carry");
    issue(8'hF8, 8'h00, "R3 decimal");
    issue(8'h78, 8'h00, "R3 irq disable");
    check("R7 irq masked", irq_take, 0);
    irq_req = 1'b0;
    write_status(8'h40);
    issue(8'hE2, 8'h00, "R4 zero mask");
    issue(8'hE2, 8'hA5, "R4 mask");
    issue(8'hE2, 8'hFF, "R4 full mask");
    issue(8'h00, 8'h12, "R9 unhandled");
    issue(8'hFF, 8'h12, "R9 unhandled");

    // write during busy is ignored (R10)
    write_status(8'h00);
    opcode = 8'h38; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; status_wr = 1'b1; status_wdata = 8'hF0;
    @(negedge clk);
    status_wr = 1'b0;
    check("R10 write ignored while busy, R2 done", done, 1);
    check("R10 write ignored while busy", status, 8'h01);
    exp_status = 8'h01;

    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] op;
      case (sel)
        0, 1: op = 8'h38;
        2: op = 8'hF8;
        3: op = 8'h78;
        4, 5, 6: op = 8'hE2;
        default: begin
          op = $urandom;
          while (op_len(op) != 1 || op == 8'hDB) op = $urandom;
        end
      endcase
      if ($urandom_range(0, 3) == 0) write_status($urandom & 8'h0F);
      irq_req = $urandom; #1;
      check("R7 irq gate", irq_take, irq_req && !exp_status[2]);
      issue(op, ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom & 8'h3F), "R2/R3/R4/R9 random");
    end

    write_status(8'h00);
    issue(8'hDB, 8'h55, "R5 stop");
    check("R5 stopped", stopped, 1);
    check("R6 step_en", step_en, 0);
    irq_req = 1'b1; #1;
    check("R7 stopped irq", irq_take, 0);
    irq_req = 1'b0;
    opcode = 8'h38; op_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R6 no done while stopped", done, 0);
    end
    op_valid = 1'b0;
    check("R6 status untouched", status, 8'h00);
    check("R5 still stopped", stopped, 1);

    do_reset();
    @(negedge clk);
    check("R1 stop cleared by reset", stopped, 0);
    check("R1 status after reset", status, 8'h04);
    issue(8'h38, 8'h00, "R2 after reset");
    summary();
  end
endmodule